// File: doc/BRIEF.md
# I2C Slave Byte Receiver with Clock Stretching

This block is the receive side of an I2C target. It watches open-drain SCL and SDA lines, recognises start, repeated-start and stop conditions, and compares the first byte after each start with a fixed 7-bit address. Once it has been addressed for a write, it shifts in each following byte. When acknowledge is enabled, it pulls SDA low for the ninth clock with no help from software.

When the ninth clock falls, the block holds SCL low and raises a transfer-end interrupt. The master then waits until software has collected the byte from the receive register. Software frees the bus in one of two ways: it pulses the wait-release input, or it writes the all-ones value through the shift-register write port. A stop condition raises an interrupt of its own. A cause flag separates the two interrupt kinds, and a read strobe clears the pending interrupt.

Both line inputs pass through a two-flop synchronizer and a glitch filter before any edge is used, so the block can take raw pad signals.

Top module: `i2cs_rx`

## Requirements
- R1: After reset the block drives neither line low (sclOe = 0, sdaOe = 0), irq is 0 and rxData is 0.
- R2: Bits are taken MSB first on SCL rising edges. After the eighth clock falls, the whole byte appears on rxData, and this happens only for bytes the block accepts.
- R3: Bits 7..1 of the first byte after a start are the address and bit 0 is the direction. The block is addressed only when the address equals OWN_ADDR and the direction bit is 0. Otherwise it gives no ACK, no stretch and no interrupt, and leaves rxData unchanged, until the next start.
- R4: When addressed and ackEnable is 1 at the fall of the eighth clock, sdaOe is 1 from that fall until the fall of the ninth clock. When ackEnable is 0, SDA is never driven.
- R5: On the fall of the ninth clock of an accepted byte, sclOe becomes 1, irq becomes 1 and irqCause becomes 0 (transfer end). This happens whether or not an ACK was given.
- R6: A one-cycle pulse on waitRelease while SCL is held drops sclOe on the next cycle, and reception continues with a fresh bit count.
- R7: A write on the shift port with shiftWrData = 8'hFF while SCL is held releases SCL like R6. A write of any other value leaves sclOe at 1.
- R8: A rising SDA while SCL is high (stop) sets irq = 1 with irqCause = 1 (stop), releases both lines and returns the block to idle.
- R9: A one-cycle pulse on causeRead clears irq, unless a new event arrives in the same cycle.
- R10: A start or repeated start in the middle of a byte releases SDA and clears the bit count, and the next byte is treated as an address.
- R11: A pulse on SCL shorter than FILT_LEN system clocks is ignored and shifts in no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL pad level |
| sdaIn | input | 1 | SDA pad level |
| sclOe | output | 1 | 1 pulls SCL low (stretch) |
| sdaOe | output | 1 | 1 pulls SDA low (ACK) |
| ackEnable | input | 1 | Acknowledge accepted bytes automatically |
| waitRelease | input | 1 | Pulse to free a held SCL |
| shiftWrEn | input | 1 | Write strobe for the shift register |
| shiftWrData | input | 8 | Shift register write value; all ones frees SCL |
| causeRead | input | 1 | Read strobe that clears the pending interrupt |
| rxData | output | 8 | Last accepted byte |
| irq | output | 1 | Interrupt pending |
| irqCause | output | 1 | 0 = transfer end, 1 = stop |

## Verification
The bench builds the block with FILT_LEN = 3 and OWN_ADDR = 7'h2A. The short filter keeps each SCL phase near ten system clocks, so all 256 data values can be sent within the run. The sweep alternates between release by pulse and release by an all-ones write, and it also tries a non-ones write first. ackEnable is turned off for one value in seven to cover the no-ACK path. The short filter also puts a single-cycle SCL glitch within reach, along with address mismatches, a read-direction address, and a repeated start that cuts a byte short.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACKW,
    ST_HOLD,
    ST_SKIP
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic clrCnt;
    logic latchRx;
    logic setXfer;
    logic setStop;
  } dpStrobe_t;
endpackage

// File: rtl/i2cs_filter.sv
module i2cs_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int FCW = $clog2(FILT_LEN + 1);

  logic [1:0]     syncQ;
  logic [FCW-1:0] stableCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= 2'b11;
      level     <= 1'b1;
      stableCnt <= '0;
      rise      <= 1'b0;
      fall      <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], lineIn};
      rise  <= 1'b0;
      fall  <= 1'b0;
      if (syncQ[1] != level) begin
        if (stableCnt == FCW'(FILT_LEN - 1)) begin
          level     <= syncQ[1];
          rise      <= syncQ[1];
          fall      <= !syncQ[1];
          stableCnt <= '0;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end else begin
        stableCnt <= '0;
      end
    end
  end

  // R11: a filtered edge must follow a full run of agreeing samples
  AST_EDGE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (rise || fall) |-> $past(syncQ[1]) == level) // R11
    else $error("filter edge without stable input");
endmodule

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              sdaLevel,
  input  logic              shiftWrEn,
  input  logic [BYTE_W-1:0] shiftWrData,
  input  logic              causeRead,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [BYTE_W-1:0] shiftByte,
  output logic [BYTE_W-1:0] rxData,
  output logic              irq,
  output logic              irqCause
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strb.clrCnt) begin
      bitCnt <= '0;
    end else if (strb.shiftEn) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftByte <= '0;
    end else if (shiftWrEn) begin
      shiftByte <= shiftWrData;
    end else if (strb.shiftEn) begin
      shiftByte <= {shiftByte[BYTE_W-2:0], sdaLevel};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
    end else if (strb.latchRx) begin
      rxData <= shiftByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq      <= 1'b0;
      irqCause <= 1'b0;
    end else if (strb.setStop) begin
      irq      <= 1'b1;
      irqCause <= 1'b1;
    end else if (strb.setXfer) begin
      irq      <= 1'b1;
      irqCause <= 1'b0;
    end else if (causeRead) begin
      irq <= 1'b0;
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W)) // R2
    else $error("bit count past byte width");

  AST_STOP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strb.setStop |=> irq && irqCause) // R8
    else $error("stop did not flag interrupt");

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    causeRead && !strb.setStop && !strb.setXfer |=> !irq) // R9
    else $error("read did not clear interrupt");
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclLevel,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              sdaRise,
  input  logic              sdaFall,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [BYTE_W-1:0] shiftByte,
  input  logic              ackEnable,
  input  logic              waitRelease,
  input  logic              shiftWrEn,
  input  logic [BYTE_W-1:0] shiftWrData,
  output dpStrobe_t         strb,
  output logic              sclOe,
  output logic              sdaOe
);
  rxState_t st, stNext;
  logic     sclOeNext, sdaOeNext;
  logic     startDet, stopDet, byteDone, addrHit, releaseReq;

  assign startDet   = sdaFall && sclLevel;
  assign stopDet    = sdaRise && sclLevel;
  assign byteDone   = sclFall && (bitCnt == CNT_W'(BYTE_W));
  assign addrHit    = (shiftByte[BYTE_W-1:1] == OWN_ADDR) && !shiftByte[0];
  assign releaseReq = waitRelease || (shiftWrEn && (shiftWrData == '1));

  always_comb begin
    stNext    = st;
    sclOeNext = sclOe;
    sdaOeNext = sdaOe;
    strb      = '0;
    if (startDet) begin
      stNext      = ST_ADDR;
      strb.clrCnt = 1'b1;
      sclOeNext   = 1'b0;
      sdaOeNext   = 1'b0;
    end else if (stopDet) begin
      stNext       = ST_IDLE;
      strb.setStop = 1'b1;
      sclOeNext    = 1'b0;
      sdaOeNext    = 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_DATA: begin
          if (sclRise && (bitCnt < CNT_W'(BYTE_W))) strb.shiftEn = 1'b1;
          if (byteDone) begin
            if (st == ST_ADDR && !addrHit) begin
              stNext = ST_SKIP;
            end else begin
              strb.latchRx = 1'b1;
              sdaOeNext    = ackEnable;
              stNext       = ST_ACKW;
            end
          end
        end
        ST_ACKW: begin
          if (sclFall) begin
            sdaOeNext    = 1'b0;
            sclOeNext    = 1'b1;
            strb.setXfer = 1'b1;
            stNext       = ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (releaseReq) begin
            sclOeNext   = 1'b0;
            strb.clrCnt = 1'b1;
            stNext      = ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= ST_IDLE;
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
    end else begin
      st    <= stNext;
      sclOe <= sclOeNext;
      sdaOe <= sdaOeNext;
    end
  end

  AST_START_FREES_SDA: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe && st == ST_ADDR) // R10
    else $error("start did not release SDA");

  AST_ACK_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> st == ST_ACKW) // R4
    else $error("SDA driven outside ACK slot");

  AST_PULSE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    st == ST_HOLD && waitRelease && !startDet && !stopDet |=> !sclOe) // R6
    else $error("wait release ignored");

  AST_ONES_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    st == ST_HOLD && shiftWrEn && shiftWrData == '1 && !startDet && !stopDet |=> !sclOe) // R7
    else $error("all-ones write did not release");

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    st == ST_SKIP |-> !sclOe && !sdaOe) // R3
    else $error("unaddressed slave drove the bus");
endmodule

// File: rtl/i2cs_rx.sv
module i2cs_rx
  import i2cs_pkg::*;
#(
  parameter int         FILT_LEN = 4,
  parameter logic [6:0] OWN_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic              ackEnable,
  input  logic              waitRelease,
  input  logic              shiftWrEn,
  input  logic [BYTE_W-1:0] shiftWrData,
  input  logic              causeRead,
  output logic [BYTE_W-1:0] rxData,
  output logic              irq,
  output logic              irqCause
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] rawLine, lvl, rEdge, fEdge;
  logic [CNT_W-1:0]   bitCnt;
  logic [BYTE_W-1:0]  shiftByte;
  dpStrobe_t          strb;

  assign rawLine = {sdaIn, sclIn};

  for (genvar g = 0; g < N_LINES; g++) begin : gLineFilt
    i2cs_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (rawLine[g]),
      .level  (lvl[g]),
      .rise   (rEdge[g]),
      .fall   (fEdge[g])
    );
  end

  i2cs_ctrl #(.OWN_ADDR(OWN_ADDR)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sclLevel    (lvl[0]),
    .sclRise     (rEdge[0]),
    .sclFall     (fEdge[0]),
    .sdaRise     (rEdge[1]),
    .sdaFall     (fEdge[1]),
    .bitCnt      (bitCnt),
    .shiftByte   (shiftByte),
    .ackEnable   (ackEnable),
    .waitRelease (waitRelease),
    .shiftWrEn   (shiftWrEn),
    .shiftWrData (shiftWrData),
    .strb        (strb),
    .sclOe       (sclOe),
    .sdaOe       (sdaOe)
  );

  i2cs_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .sdaLevel    (lvl[1]),
    .shiftWrEn   (shiftWrEn),
    .shiftWrData (shiftWrData),
    .causeRead   (causeRead),
    .bitCnt      (bitCnt),
    .shiftByte   (shiftByte),
    .rxData      (rxData),
    .irq         (irq),
    .irqCause    (irqCause)
  );

  AST_HOLD_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOe) |-> irq && !irqCause) // R5
    else $error("stretch without transfer interrupt");
endmodule

// File: tb/i2cs_rx_bench.sv
module i2cs_rx_bench;
  localparam int Q = 10;
  localparam logic [6:0] ADDR = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclOe, sdaOe, irq, irqCause;
  logic ackEnable = 1'b1, waitRelease = 1'b0, shiftWrEn = 1'b0, causeRead = 1'b0;
  logic [7:0] shiftWrData = 8'h00;
  logic [7:0] rxData;
  logic sclLine, sdaLine;
  int checks = 0, fails = 0;
  bit  ackSeen, held, glitchOn = 1'b0;

  always #2.5 clk = ~clk;

  assign sclLine = mScl & ~sclOe;
  assign sdaLine = mSda & ~sdaOe;

  i2cs_rx #(.FILT_LEN(3), .OWN_ADDR(ADDR)) u_i2cs_rx (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .ackEnable(ackEnable),
    .waitRelease(waitRelease), .shiftWrEn(shiftWrEn), .shiftWrData(shiftWrData),
    .causeRead(causeRead), .rxData(rxData), .irq(irq), .irqCause(irqCause)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitSclHigh();
    while (!sclLine) @(negedge clk);
  endtask

  task automatic doStart();
    if (!mScl) begin
      mSda = 1'b1; q();
      mScl = 1'b1; waitSclHigh(); q();
    end
    mSda = 1'b0; q();
    mScl = 1'b0; q();
  endtask

  task automatic doStop();
    mSda = 1'b0; q();
    mScl = 1'b1; waitSclHigh(); q();
    mSda = 1'b1; q();
  endtask

  task automatic bitOut(input bit b);
    mSda = b;
    if (glitchOn) begin
      q(3); mScl = 1'b1; q(1); mScl = 1'b0; q(Q - 4);
    end else begin
      q();
    end
    mScl = 1'b1; waitSclHigh(); q();
    mScl = 1'b0; q();
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bitOut(b[i]);
    mSda = 1'b1; q();
    mScl = 1'b1; waitSclHigh(); q();
    ackSeen = !sdaLine;
    mScl = 1'b0; q();
    held = sclOe;
  endtask

  task automatic pulseRead();
    causeRead = 1'b1; q(1); causeRead = 1'b0;
  endtask

  task automatic pulseRelease();
    waitRelease = 1'b1; q(1); waitRelease = 1'b0; q(1);
  endtask

  task automatic writeShift(input logic [7:0] v);
    shiftWrData = v; shiftWrEn = 1'b1; q(1); shiftWrEn = 1'b0; q(1);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    logic [7:0] lastRx;
    q(3);
    // R1 reset state
    chk(sclOe == 0 && sdaOe == 0, "R1", {sclOe, sdaOe}, 0);
    chk(irq == 0 && rxData == 0, "R1", {irq, rxData}, 0);
    rstN = 1'b1; q(5);

    // address hit
    doStart();
    sendByte({ADDR, 1'b0});
    chk(ackSeen, "R3", ackSeen, 1);
    chk(held, "R5", held, 1);
    chk(irq && !irqCause, "R5", {irq, irqCause}, 2);
    chk(rxData == {ADDR, 1'b0}, "R2", rxData, {ADDR, 1'b0});
    pulseRead(); q(1);
    chk(!irq, "R9", irq, 0);
    pulseRelease();
    chk(!sclOe, "R6", sclOe, 0);

    // sweep of every data value
    for (int v = 0; v < 256; v++) begin
      ackEnable = (v % 7 != 3);
      sendByte(v[7:0]);
      chk(ackSeen == ackEnable, "R4", ackSeen, ackEnable);
      chk(held, "R5", held, 1);
      chk(irq && !irqCause, "R5", {irq, irqCause}, 2);
      chk(rxData == v[7:0], "R2", rxData, v);
      pulseRead();
      if (v % 2 == 0) begin
        pulseRelease();
        chk(!sclOe, "R6", sclOe, 0);
      end else begin
        writeShift(8'h7E);
        chk(sclOe, "R7", sclOe, 1);
        writeShift(8'hFF);
        chk(!sclOe, "R7", sclOe, 0);
      end
    end
    ackEnable = 1'b1;

    // glitch on SCL during every bit
    glitchOn = 1'b1;
    sendByte(8'hA5);
    glitchOn = 1'b0;
    chk(rxData == 8'hA5, "R11", rxData, 8'hA5);
    chk(ackSeen && held, "R11", {ackSeen, held}, 3);
    pulseRead(); pulseRelease();

    // stop
    doStop(); q(2);
    chk(irq && irqCause, "R8", {irq, irqCause}, 3);
    chk(!sclOe && !sdaOe, "R8", {sclOe, sdaOe}, 0);
    pulseRead(); q(1);
    chk(!irq, "R9", irq, 0);

    // address mismatch, then an ignored data byte
    lastRx = rxData;
    doStart();
    sendByte({ADDR + 7'd1, 1'b0});
    chk(!ackSeen && !held, "R3", {ackSeen, held}, 0);
    chk(!irq, "R3", irq, 0);
    sendByte(8'h33);
    chk(!ackSeen && !held, "R3", {ackSeen, held}, 0);
    chk(rxData == lastRx, "R3", rxData, lastRx);
    doStop(); q(2); pulseRead(); q(1);

    // matching address with read direction
    doStart();
    sendByte({ADDR, 1'b1});
    chk(!ackSeen && !held && !irq, "R3", {ackSeen, held, irq}, 0);
    doStop(); q(2); pulseRead(); q(1);

    // repeated start cutting a byte short
    doStart();
    sendByte({ADDR, 1'b0});
    pulseRead(); pulseRelease();
    sendByte(8'h0F);
    chk(rxData == 8'h0F, "R2", rxData, 8'h0F);
    pulseRead(); pulseRelease();
    bitOut(1'b1); bitOut(1'b1); bitOut(1'b1);
    doStart();
    chk(!sdaOe && !sclOe, "R10", {sdaOe, sclOe}, 0);
    sendByte({ADDR, 1'b0});
    chk(ackSeen && held, "R10", {ackSeen, held}, 3);
    chk(rxData == {ADDR, 1'b0}, "R10", rxData, {ADDR, 1'b0});
    pulseRead(); pulseRelease();
    doStop(); q(2);
    chk(irq && irqCause, "R8", {irq, irqCause}, 3);

    summary();
  end
endmodule